// File: doc/BRIEF.md
# Two-Level Ring Hierarchy Level Switch

This block joins one local ring to the central ring of a two-level ring hierarchy. Both rings are slotted: every clock cycle each slot, full or empty, moves one node onward. A packet's destination is a routing mask made of two fields. The ring field has one bit per local ring attached to the central ring. The station field has one bit per station on a local ring. Multicast masks are the bitwise OR of point-to-point masks. Every station whose ring bit and station bit are both set therefore receives the packet, including stations that no sender meant to reach.

On the local-ring side the switch looks only at the ring field. Any set bit there marks the packet as bound upward, so the switch pulls it off the local ring and queues it for the central ring. A packet with a zero ring field is local traffic and continues along the local ring.

On the central-ring side the switch looks only at its own ring bit. When that bit is set, the switch queues a copy for the local ring with the whole ring field cleared. The slot then keeps moving with the switch's own bit cleared, or it is emptied if no ring bit remains.

Each direction has a small FIFO. A queued packet enters its target ring only through an empty or freed slot. When a FIFO is full, the packet it would have taken is left on its ring unchanged, so nothing is dropped.

Top module: `ring_level_switch`

## Requirements
- R1: While reset is held and after it is released with idle inputs, the valid flag of both output slots is 0.
- R2: A valid local-ring slot whose ring field (bit i = local ring i) is nonzero is removed from the local ring. When the upward FIFO has room, it later leaves on the central-ring output with its ring field, station field and payload unchanged.
- R3: A valid local-ring slot with a zero ring field appears unchanged on the local-ring output one cycle after it arrives.
- R4: A valid central-ring slot whose ring field has bit RING_ID set is copied onto the local-ring output. The copy has an all-zero ring field and the same station field and payload.
- R5: After such a copy is taken, the central-ring slot continues with bit RING_ID cleared if other ring bits remain set. Otherwise the slot leaves empty.
- R6: A valid central-ring slot whose bit RING_ID is clear leaves on the central-ring output unchanged one cycle after it arrives.
- R7: For a chain of switches with ring IDs 0..3, a central-ring packet reaches exactly the (ring, station) pairs that form the cross product of its set ring bits and its set station bits. Each reached ring sees exactly one copy.
- R8: Each direction queues up to FIFO_DEPTH (default 4) packets and delivers them in arrival order.
- R9: When the downward FIFO is full, a central-ring slot carrying bit RING_ID passes on unchanged, with that bit still set.
- R10: When the upward FIFO is full, an ascending local-ring slot stays on the local ring unchanged.
- R11: A queued packet is inserted only into an empty or freed slot. Traffic that passes through is never overwritten or lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lo_in_vld | input | 1 | Local-ring incoming slot is full |
| lo_in_ring | input | RS_NRING | Incoming local slot ring field |
| lo_in_stn | input | RS_NSTN | Incoming local slot station field |
| lo_in_data | input | RS_DW | Incoming local slot payload |
| up_in_vld | input | 1 | Central-ring incoming slot is full |
| up_in_ring | input | RS_NRING | Incoming central slot ring field |
| up_in_stn | input | RS_NSTN | Incoming central slot station field |
| up_in_data | input | RS_DW | Incoming central slot payload |
| lo_out_vld | output | 1 | Local-ring outgoing slot is full |
| lo_out_ring | output | RS_NRING | Outgoing local slot ring field |
| lo_out_stn | output | RS_NSTN | Outgoing local slot station field |
| lo_out_data | output | RS_DW | Outgoing local slot payload |
| up_out_vld | output | 1 | Central-ring outgoing slot is full |
| up_out_ring | output | RS_NRING | Outgoing central slot ring field |
| up_out_stn | output | RS_NSTN | Outgoing central slot station field |
| up_out_data | output | RS_DW | Outgoing central slot payload |

## Verification
The assertions rely on two things about the environment. Reset must be held low for at least two clock edges. Each incoming slot must hold its value for a whole cycle, so that a slot sampled on one edge can be compared with what leaves on the next.

The bench meets both conditions. It changes inputs only on the falling clock edge and holds every slot for exactly one cycle. It returns idle slots to all zeros, and it keeps the central-ring filler traffic free of ring bits, so the filler never hits any switch.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int unsigned RS_NRING = 4;
  parameter int unsigned RS_NSTN  = 4;
  parameter int unsigned RS_DW    = 16;

  typedef struct packed {
    logic                vld;
    logic [RS_NRING-1:0] ring;
    logic [RS_NSTN-1:0]  stn;
    logic [RS_DW-1:0]    data;
  } rs_slot_t;
endpackage

// File: rtl/rs_fifo.sv
module rs_fifo
  import rs_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rs_slot_t din,
  input  logic     pop,
  output rs_slot_t dout,
  output logic     full,
  output logic     empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   CAP  = (AW+1)'(DEPTH);

  rs_slot_t        mem [DEPTH];
  logic [AW-1:0]   rd_q, rd_nxt, wr_q, wr_nxt;
  logic [AW:0]     cnt_q, cnt_nxt;
  logic            push_ok, pop_ok;

  always_comb begin
    full    = (cnt_q == CAP);
    empty   = (cnt_q == '0);
    push_ok = push && !full;
    pop_ok  = pop && !empty;
    wr_nxt  = wr_q;
    rd_nxt  = rd_q;
    cnt_nxt = cnt_q;
    if (push_ok) wr_nxt = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_nxt = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_nxt = cnt_q + 1'b1;
      2'b01:   cnt_nxt = cnt_q - 1'b1;
      default: cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_nxt;
      wr_q  <= wr_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign dout = mem[rd_q];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP); // R8
endmodule

// File: rtl/rs_up_side.sv
module rs_up_side
  import rs_pkg::*;
#(
  parameter int unsigned RING_ID = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  rs_slot_t in_slot,
  input  logic     dn_full,
  input  rs_slot_t up_head,
  input  logic     up_empty,
  output rs_slot_t out_slot,
  output logic     dn_push,
  output rs_slot_t dn_pkt,
  output logic     up_pop
);
  localparam logic [RS_NRING-1:0] OWN_BIT = RS_NRING'(1) << RING_ID;

  logic                hit;
  logic [RS_NRING-1:0] rest;
  rs_slot_t            pass_slot, out_nxt, out_q;

  always_comb begin
    hit       = in_slot.vld && ((in_slot.ring & OWN_BIT) != '0);
    rest      = in_slot.ring & ~OWN_BIT;
    dn_push   = hit && !dn_full;
    dn_pkt    = in_slot;
    dn_pkt.ring = '0;
    pass_slot = in_slot;
    if (dn_push) begin
      pass_slot.ring = rest;
      if (rest == '0) pass_slot = '0;
    end
    up_pop  = !pass_slot.vld && !up_empty;
    out_nxt = up_pop ? up_head : pass_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_nxt;
  end

  assign out_slot = out_q;

  AST_UP_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot.vld && !in_slot.ring[RING_ID]) |=> (out_slot == $past(in_slot))); // R6
  AST_UP_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot.vld && in_slot.ring[RING_ID] && dn_full) |=> (out_slot == $past(in_slot))); // R9
  AST_UP_REST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_push && rest != '0) |=> (out_slot.vld && !out_slot.ring[RING_ID]
                                 && out_slot.data == $past(in_slot.data))); // R5
  AST_UP_COPY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dn_push |-> (dn_pkt.ring == '0 && dn_pkt.stn == in_slot.stn)); // R4
endmodule

// File: rtl/rs_lo_side.sv
module rs_lo_side
  import rs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  rs_slot_t in_slot,
  input  logic     up_full,
  input  rs_slot_t dn_head,
  input  logic     dn_empty,
  output rs_slot_t out_slot,
  output logic     up_push,
  output rs_slot_t up_pkt,
  output logic     dn_pop
);
  logic     asc;
  rs_slot_t pass_slot, out_nxt, out_q;

  always_comb begin
    asc       = in_slot.vld && (in_slot.ring != '0);
    up_push   = asc && !up_full;
    up_pkt    = in_slot;
    pass_slot = up_push ? '0 : in_slot;
    dn_pop    = !pass_slot.vld && !dn_empty;
    out_nxt   = dn_pop ? dn_head : pass_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_nxt;
  end

  assign out_slot = out_q;

  AST_LO_LOCAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot.vld && in_slot.ring == '0) |=> (out_slot == $past(in_slot))); // R3
  AST_LO_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (asc && up_full) |=> (out_slot == $past(in_slot))); // R10
  AST_LO_ASC_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    up_push |=> (out_slot.ring == '0)); // R2
  AST_LO_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_pop |-> !(in_slot.vld && in_slot.ring == '0)); // R11
endmodule

// File: rtl/ring_level_switch.sv
module ring_level_switch
  import rs_pkg::*;
#(
  parameter int unsigned RING_ID    = 0,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lo_in_vld,
  input  logic [RS_NRING-1:0] lo_in_ring,
  input  logic [RS_NSTN-1:0]  lo_in_stn,
  input  logic [RS_DW-1:0]    lo_in_data,
  input  logic                up_in_vld,
  input  logic [RS_NRING-1:0] up_in_ring,
  input  logic [RS_NSTN-1:0]  up_in_stn,
  input  logic [RS_DW-1:0]    up_in_data,
  output logic                lo_out_vld,
  output logic [RS_NRING-1:0] lo_out_ring,
  output logic [RS_NSTN-1:0]  lo_out_stn,
  output logic [RS_DW-1:0]    lo_out_data,
  output logic                up_out_vld,
  output logic [RS_NRING-1:0] up_out_ring,
  output logic [RS_NSTN-1:0]  up_out_stn,
  output logic [RS_DW-1:0]    up_out_data
);
  logic [1:0] rst_sync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  rs_slot_t lo_in_s, up_in_s, lo_out_s, up_out_s;
  rs_slot_t up_push_pkt, up_head, dn_push_pkt, dn_head;
  logic     up_push, up_pop, up_full, up_empty;
  logic     dn_push, dn_pop, dn_full, dn_empty;

  assign lo_in_s = '{vld: lo_in_vld, ring: lo_in_ring, stn: lo_in_stn, data: lo_in_data};
  assign up_in_s = '{vld: up_in_vld, ring: up_in_ring, stn: up_in_stn, data: up_in_data};

  rs_fifo #(.DEPTH(FIFO_DEPTH)) u_up_q (
    .clk(clk), .rst_n(rst_s), .push(up_push), .din(up_push_pkt),
    .pop(up_pop), .dout(up_head), .full(up_full), .empty(up_empty));

  rs_fifo #(.DEPTH(FIFO_DEPTH)) u_dn_q (
    .clk(clk), .rst_n(rst_s), .push(dn_push), .din(dn_push_pkt),
    .pop(dn_pop), .dout(dn_head), .full(dn_full), .empty(dn_empty));

  rs_lo_side u_lo (
    .clk(clk), .rst_n(rst_s), .in_slot(lo_in_s), .up_full(up_full),
    .dn_head(dn_head), .dn_empty(dn_empty), .out_slot(lo_out_s),
    .up_push(up_push), .up_pkt(up_push_pkt), .dn_pop(dn_pop));

  rs_up_side #(.RING_ID(RING_ID)) u_up (
    .clk(clk), .rst_n(rst_s), .in_slot(up_in_s), .dn_full(dn_full),
    .up_head(up_head), .up_empty(up_empty), .out_slot(up_out_s),
    .dn_push(dn_push), .dn_pkt(dn_push_pkt), .up_pop(up_pop));

  assign lo_out_vld  = lo_out_s.vld;
  assign lo_out_ring = lo_out_s.ring;
  assign lo_out_stn  = lo_out_s.stn;
  assign lo_out_data = lo_out_s.data;
  assign up_out_vld  = up_out_s.vld;
  assign up_out_ring = up_out_s.ring;
  assign up_out_stn  = up_out_s.stn;
  assign up_out_data = up_out_s.data;

  AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_s |=> (!lo_out_vld && !up_out_vld)); // R1
endmodule

// File: tb/sim_ring_level_switch.sv
module sim_ring_level_switch;
  import rs_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // local ring stimulus / observation per switch
  logic                lo_iv [4];
  logic [RS_NRING-1:0] lo_ir [4];
  logic [RS_NSTN-1:0]  lo_is [4];
  logic [RS_DW-1:0]    lo_id [4];
  logic                lo_ov [4];
  logic [RS_NRING-1:0] lo_or [4];
  logic [RS_NSTN-1:0]  lo_os [4];
  logic [RS_DW-1:0]    lo_od [4];
  // central ring chain: c*[0] driven by bench, c*[k+1] from switch k
  logic                cv [5];
  logic [RS_NRING-1:0] cr [5];
  logic [RS_NSTN-1:0]  cs [5];
  logic [RS_DW-1:0]    cd [5];

  ring_level_switch #(.RING_ID(0)) u0 (.clk(clk), .rst_n(rst_n),
    .lo_in_vld(lo_iv[0]), .lo_in_ring(lo_ir[0]), .lo_in_stn(lo_is[0]), .lo_in_data(lo_id[0]),
    .up_in_vld(cv[0]), .up_in_ring(cr[0]), .up_in_stn(cs[0]), .up_in_data(cd[0]),
    .lo_out_vld(lo_ov[0]), .lo_out_ring(lo_or[0]), .lo_out_stn(lo_os[0]), .lo_out_data(lo_od[0]),
    .up_out_vld(cv[1]), .up_out_ring(cr[1]), .up_out_stn(cs[1]), .up_out_data(cd[1]));
  ring_level_switch #(.RING_ID(1)) u1 (.clk(clk), .rst_n(rst_n),
    .lo_in_vld(lo_iv[1]), .lo_in_ring(lo_ir[1]), .lo_in_stn(lo_is[1]), .lo_in_data(lo_id[1]),
    .up_in_vld(cv[1]), .up_in_ring(cr[1]), .up_in_stn(cs[1]), .up_in_data(cd[1]),
    .lo_out_vld(lo_ov[1]), .lo_out_ring(lo_or[1]), .lo_out_stn(lo_os[1]), .lo_out_data(lo_od[1]),
    .up_out_vld(cv[2]), .up_out_ring(cr[2]), .up_out_stn(cs[2]), .up_out_data(cd[2]));
  ring_level_switch #(.RING_ID(2)) u2 (.clk(clk), .rst_n(rst_n),
    .lo_in_vld(lo_iv[2]), .lo_in_ring(lo_ir[2]), .lo_in_stn(lo_is[2]), .lo_in_data(lo_id[2]),
    .up_in_vld(cv[2]), .up_in_ring(cr[2]), .up_in_stn(cs[2]), .up_in_data(cd[2]),
    .lo_out_vld(lo_ov[2]), .lo_out_ring(lo_or[2]), .lo_out_stn(lo_os[2]), .lo_out_data(lo_od[2]),
    .up_out_vld(cv[3]), .up_out_ring(cr[3]), .up_out_stn(cs[3]), .up_out_data(cd[3]));
  ring_level_switch #(.RING_ID(3)) u3 (.clk(clk), .rst_n(rst_n),
    .lo_in_vld(lo_iv[3]), .lo_in_ring(lo_ir[3]), .lo_in_stn(lo_is[3]), .lo_in_data(lo_id[3]),
    .up_in_vld(cv[3]), .up_in_ring(cr[3]), .up_in_stn(cs[3]), .up_in_data(cd[3]),
    .lo_out_vld(lo_ov[3]), .lo_out_ring(lo_or[3]), .lo_out_stn(lo_os[3]), .lo_out_data(lo_od[3]),
    .up_out_vld(cv[4]), .up_out_ring(cr[4]), .up_out_stn(cs[4]), .up_out_data(cd[4]));

  // receive logs
  int                  rx_cnt [4];
  logic [RS_DW-1:0]    rx_dat [4][32];
  logic [RS_NSTN-1:0]  rx_stn [4];
  logic [RS_NRING-1:0] rx_rng [4];
  int                  end_cnt;
  logic [RS_DW-1:0]    end_dat [32];
  logic [RS_NRING-1:0] end_rng [32];
  logic [RS_NSTN-1:0]  end_stn [32];

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (lo_ov[i] === 1'b1) begin
        if (rx_cnt[i] < 32) rx_dat[i][rx_cnt[i]] = lo_od[i];
        rx_stn[i] = lo_os[i];
        rx_rng[i] = lo_or[i];
        rx_cnt[i] = rx_cnt[i] + 1;
      end
    end
    if (cv[4] === 1'b1) begin
      if (end_cnt < 32) begin
        end_dat[end_cnt] = cd[4];
        end_rng[end_cnt] = cr[4];
        end_stn[end_cnt] = cs[4];
      end
      end_cnt = end_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_logs();
    for (int i = 0; i < 4; i++) begin
      rx_cnt[i] = 0; rx_stn[i] = '0; rx_rng[i] = '0;
    end
    end_cnt = 0;
  endtask

  task automatic idle_all();
    for (int i = 0; i < 4; i++) begin
      lo_iv[i] = 1'b0; lo_ir[i] = '0; lo_is[i] = '0; lo_id[i] = '0;
    end
    cv[0] = 1'b0; cr[0] = '0; cs[0] = '0; cd[0] = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_central(input logic [3:0] rm, input logic [3:0] sm, input logic [15:0] d);
    @(negedge clk);
    cv[0] = 1'b1; cr[0] = rm; cs[0] = sm; cd[0] = d;
    @(negedge clk);
    cv[0] = 1'b0; cr[0] = '0; cs[0] = '0; cd[0] = '0;
  endtask

  // R1
  task automatic t_reset();
    wait_cyc(2);
    for (int i = 0; i < 4; i++) chk(lo_ov[i] === 1'b0, "R1 local out idle in reset", lo_ov[i], 0);
    chk(cv[4] === 1'b0, "R1 central out idle in reset", cv[4], 0);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(4);
    for (int i = 0; i < 4; i++) chk(lo_ov[i] === 1'b0, "R1 local out idle after reset", lo_ov[i], 0);
    chk(cv[4] === 1'b0, "R1 central out idle after reset", cv[4], 0);
  endtask

  // R4 R5 R7: cross product of ring bits and station bits
  task automatic t_deliver(input logic [3:0] rm, input logic [3:0] sm, input logic [15:0] d);
    clr_logs();
    send_central(rm, sm, d);
    wait_cyc(12);
    for (int i = 0; i < 4; i++) begin
      chk(rx_cnt[i] == (rm[i] ? 1 : 0), "R7 copies per ring", rx_cnt[i], rm[i] ? 1 : 0);
      if (rm[i]) begin
        chk(rx_stn[i] == sm, "R7 station set on reached ring", rx_stn[i], sm);
        chk(rx_rng[i] == 4'b0, "R4 ring field zero on descent", rx_rng[i], 0);
        chk(rx_dat[i][0] == d, "R4 payload kept", rx_dat[i][0], d);
      end
    end
    chk(end_cnt == 0, "R5 slot emptied after last ring bit", end_cnt, 0);
  endtask

  // R6 R5: exact per-hop timing of a packet bound for ring 3
  task automatic t_miss_hops();
    clr_logs();
    @(negedge clk);
    cv[0] = 1'b1; cr[0] = 4'b1000; cs[0] = 4'b0110; cd[0] = 16'h6A6A;
    @(negedge clk);
    cv[0] = 1'b0; cr[0] = '0; cs[0] = '0; cd[0] = '0;
    chk(cv[1] && cr[1] == 4'b1000 && cd[1] == 16'h6A6A, "R6 pass switch 0", {cv[1], cr[1]}, 5'h18);
    @(negedge clk);
    chk(cv[2] && cr[2] == 4'b1000 && cs[2] == 4'b0110, "R6 pass switch 1", {cv[2], cr[2]}, 5'h18);
    @(negedge clk);
    chk(cv[3] && cr[3] == 4'b1000 && cd[3] == 16'h6A6A, "R6 pass switch 2", {cv[3], cr[3]}, 5'h18);
    @(negedge clk);
    chk(cv[4] === 1'b0, "R5 slot emptied at switch 3", cv[4], 0);
    wait_cyc(4);
    chk(rx_cnt[3] == 1 && rx_stn[3] == 4'b0110, "R4 copy on ring 3", rx_cnt[3], 1);
  endtask

  // R5: partial clear while bits remain (observe between switches)
  task automatic t_partial_clear();
    @(negedge clk);
    cv[0] = 1'b1; cr[0] = 4'b1011; cs[0] = 4'b0001; cd[0] = 16'h5151;
    @(negedge clk);
    cv[0] = 1'b0; cr[0] = '0; cs[0] = '0; cd[0] = '0;
    chk(cv[1] && cr[1] == 4'b1010, "R5 own bit cleared at switch 0", cr[1], 4'b1010);
    @(negedge clk);
    chk(cv[2] && cr[2] == 4'b1000, "R5 own bit cleared at switch 1", cr[2], 4'b1000);
    wait_cyc(8);
  endtask

  // R3: local traffic passes in one cycle
  task automatic t_local_pass();
    @(negedge clk);
    lo_iv[2] = 1'b1; lo_ir[2] = '0; lo_is[2] = 4'b0101; lo_id[2] = 16'hC3C3;
    @(negedge clk);
    lo_iv[2] = 1'b0; lo_is[2] = '0; lo_id[2] = '0;
    chk(lo_ov[2] && lo_os[2] == 4'b0101 && lo_od[2] == 16'hC3C3 && lo_or[2] == 4'b0,
        "R3 local pass one cycle", lo_od[2], 16'hC3C3);
    @(negedge clk);
    chk(lo_ov[2] === 1'b0, "R3 no echo", lo_ov[2], 0);
    wait_cyc(3);
  endtask

  // R2: ascending packet leaves on central ring unchanged
  task automatic t_ascend();
    clr_logs();
    @(negedge clk);
    lo_iv[3] = 1'b1; lo_ir[3] = 4'b0010; lo_is[3] = 4'b0100; lo_id[3] = 16'h2B2B;
    @(negedge clk);
    lo_iv[3] = 1'b0; lo_ir[3] = '0; lo_is[3] = '0; lo_id[3] = '0;
    chk(lo_ov[3] === 1'b0, "R2 removed from local ring", lo_ov[3], 0);
    wait_cyc(4);
    chk(end_cnt == 1, "R2 one packet upward", end_cnt, 1);
    chk(end_rng[0] == 4'b0010 && end_stn[0] == 4'b0100 && end_dat[0] == 16'h2B2B,
        "R2 mask and payload unchanged", {end_rng[0], end_stn[0]}, 8'h24);
    chk(rx_cnt[3] == 0, "R2 nothing left on local ring", rx_cnt[3], 0);
  endtask

  // R8 R9 R11: downward FIFO fills while local ring is busy
  task automatic t_down_full();
    clr_logs();
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      lo_iv[0] = 1'b1; lo_ir[0] = '0; lo_is[0] = 4'b0001; lo_id[0] = 16'hA000 + 16'(k);
      if (k >= 2 && k <= 6) begin
        cv[0] = 1'b1; cr[0] = 4'b0001; cs[0] = 4'b1000; cd[0] = 16'(k - 1);
      end else begin
        cv[0] = 1'b0; cr[0] = '0; cs[0] = '0; cd[0] = '0;
      end
    end
    @(negedge clk);
    idle_all();
    wait_cyc(12);
    chk(rx_cnt[0] == 16, "R11 all local plus queued delivered", rx_cnt[0], 16);
    for (int k = 0; k < 12; k++)
      chk(rx_dat[0][k] == 16'hA000 + 16'(k), "R11 local traffic intact", rx_dat[0][k], 16'hA000 + k);
    for (int k = 0; k < 4; k++)
      chk(rx_dat[0][12+k] == 16'(k + 1), "R8 downward order", rx_dat[0][12+k], k + 1);
    chk(end_cnt == 1, "R9 overflow packet kept circulating", end_cnt, 1);
    chk(end_rng[0] == 4'b0001 && end_dat[0] == 16'h0005, "R9 own bit still set",
        {end_rng[0], end_dat[0]}, 20'h10005);
  endtask

  // R8 R10 R11: upward FIFO fills while central ring is busy
  task automatic t_up_full();
    int n_asc;
    clr_logs();
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      cv[0] = 1'b1; cr[0] = '0; cs[0] = '0; cd[0] = 16'hF000 + 16'(k);
      if (k >= 6 && k <= 10) begin
        lo_iv[3] = 1'b1; lo_ir[3] = 4'b0001; lo_is[3] = 4'b0010; lo_id[3] = 16'(k + 5);
      end else begin
        lo_iv[3] = 1'b0; lo_ir[3] = '0; lo_is[3] = '0; lo_id[3] = '0;
      end
    end
    @(negedge clk);
    idle_all();
    wait_cyc(14);
    chk(rx_cnt[3] == 1, "R10 overflow stays on local ring", rx_cnt[3], 1);
    chk(rx_dat[3][0] == 16'd15 && rx_rng[3] == 4'b0001, "R10 unchanged", rx_dat[3][0], 15);
    chk(end_cnt == 20, "R11 filler plus queued on central", end_cnt, 20);
    n_asc = 0;
    for (int k = 0; k < 20; k++) begin
      if (k < 16)
        chk(end_dat[k] == 16'hF000 + 16'(k), "R11 filler intact", end_dat[k], 16'hF000 + k);
      else begin
        chk(end_dat[k] == 16'(11 + n_asc) && end_rng[k] == 4'b0001, "R8 upward order",
            end_dat[k], 11 + n_asc);
        n_asc++;
      end
    end
  endtask

  initial begin
    idle_all();
    clr_logs();
    t_reset();
    t_deliver(4'b0001, 4'b0001, 16'h0101);
    t_deliver(4'b0010, 4'b1000, 16'h0202);
    t_deliver(4'b0100, 4'b0100, 16'h0303);
    t_deliver(4'b1000, 4'b0010, 16'h0404);
    t_deliver(4'b0011, 4'b0011, 16'h0505);
    t_deliver(4'b0101, 4'b1010, 16'h0606);
    t_deliver(4'b1111, 4'b0110, 16'h0707);
    t_miss_hops();
    t_partial_clear();
    t_local_pass();
    t_ascend();
    t_down_full();
    t_up_full();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule